// File: doc/BRIEF.md
# PLL Retune Sequencer

This block moves a fractional-N PLL to a new reference source and multiplier while the clock it feeds stays in use. A request carries the new integer feedback divider, a 16-bit fraction with its own enable flag, an output divide-by-2 flag, a 3-bit reference select and a word of loop-configuration bits. The sequencer puts the PLL into bypass, so that downstream logic runs from the reference while the PLL is retuned. It then writes the new settings and pulses the PLL reset, because the PLL only picks up new settings on that pulse. Next it waits for lock, and only after lock does it take the PLL out of bypass. A lock timeout stops the wait, leaves the PLL in bypass and raises a sticky error flag.

Requests use a valid/ready handshake. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so a requester that has a request pending simply holds `req_valid` and its fields until it sees ready. The half flag is meant for output frequencies below the VCO range: software doubles the multiplier and sets the flag. For example, a 27 MHz reference with a multiplier of 80.75 (divider 50h, fraction C000h) and the flag set gives 1090.125 MHz. Source code 100b selects the video reference clock. The sequencer passes all of these fields through unchanged.

Top module: `pll_retune_seq`

## Requirements
- R1: After system reset, `pll_bypass`=1, `pll_reset`=0, `busy`=0, `done`=0, `timeout_err`=0 and `req_ready`=1. The divider, half, source and loop-configuration outputs take their default parameter values, and `pll_fracword` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high exactly when the sequencer is idle, and `busy` is its inverse.
- R3: A request presented while busy is ignored. It changes no output and does not start a second sequence after the current one ends.
- R4: `pll_bypass` is high from the acceptance edge through the reset pulse and the lock wait. It falls only together with `done`.
- R5: `pll_fbdiv`, `pll_half` and `pll_src` are written first, `pll_loopcfg` second and `pll_fracword` third, each one cycle apart. `pll_fracword` has the enable in bit 31, the fraction in bits 15:0 and zeros in bits 30:16 (enable 1 and fraction C000h give 8000_C000h). The outputs equal the request fields and stay stable while `pll_reset` is high.
- R6: `pll_reset` rises one cycle after the fractional write. It stays high for exactly `RST_CYC` cycles, and `RST_CYC` must be at least 4.
- R7: `pll_lock` passes through a two-flop synchronizer. `done` is a single-cycle pulse in the cycle where `pll_bypass` falls. It is issued only after a synchronized lock is seen in the wait state, which begins `SETTLE_CYC` cycles after the reset falls.
- R8: If lock is not seen within `LOCK_TO` cycles of the wait state, the sequence ends without `done` and `pll_bypass` stays 1. `timeout_err` is set and stays set until the next accepted request clears it. With the defaults, `busy` is high for 5+`RST_CYC`+`SETTLE_CYC`+`LOCK_TO` cycles.
- R9: All PLL setting outputs hold their values while idle, including after a timeout.
- R10: If lock is already high at acceptance, `busy` still lasts exactly 6+`RST_CYC`+`SETTLE_CYC` cycles. A lock that is present early does not shorten the reset or the settle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | request valid |
| req_ready | output | 1 | sequencer idle, request can be taken |
| req_fbdiv | input | FB_W | integer feedback divider |
| req_frac | input | 16 | fractional part of the multiplier |
| req_frac_en | input | 1 | enable fractional mode |
| req_half | input | 1 | output divide-by-2 |
| req_src | input | 3 | reference source select |
| req_loopcfg | input | CFG_W | loop configuration bits |
| pll_lock | input | 1 | PLL lock, asynchronous |
| pll_bypass | output | 1 | PLL bypass |
| pll_reset | output | 1 | PLL reset |
| pll_fbdiv | output | FB_W | divider to PLL |
| pll_half | output | 1 | divide-by-2 to PLL |
| pll_src | output | 3 | source select to PLL |
| pll_loopcfg | output | CFG_W | loop configuration to PLL |
| pll_fracword | output | 32 | packed fractional configuration word |
| busy | output | 1 | sequence in progress |
| done | output | 1 | one-cycle pulse when bypass is released |
| timeout_err | output | 1 | sticky lock-timeout flag |

## Verification
The bench holds lock high through the whole request. A design that trusted an early lock would leave bypass before the reset and settle time had run, and the busy length would come out short. The bench also never gives lock. A design with a broken timeout would hang, and one that dropped bypass on abort would hand downstream logic an unlocked clock. It pulses requests while busy: a design that took them would corrupt the outputs or start a phantom second sequence. It also checks that a timeout flag survives idle cycles and is cleared only by the next request. Every reset pulse is timed, and every output field is compared at the moment reset rises, which catches settings written after the pulse started.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;
  localparam int FRAC_W   = 16;
  localparam int SRC_W    = 3;
  localparam int WORD_W   = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ENTER, ST_WR_DIV, ST_WR_CFG, ST_WR_FRAC, ST_RST, ST_SETTLE, ST_WAIT
  } seq_state_e;

  // enable in the top bit, fraction in the low bits, zero between
  function automatic logic [WORD_W-1:0] pack_frac(input logic en, input logic [FRAC_W-1:0] f);
    return {en, {(WORD_W-FRAC_W-1){1'b0}}, f};
  endfunction
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_retune_pkg::*;
#(
  parameter int RST_CYC    = 4,
  parameter int SETTLE_CYC = 3,
  parameter int LOCK_TO    = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic lock_s,
  output logic idle,
  output logic ld_div,
  output logic ld_cfg,
  output logic ld_frac,
  output logic bypass,
  output logic pll_rst,
  output logic done,
  output logic timeout_err
);
  localparam int M1    = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int MAXC  = (M1 > LOCK_TO) ? M1 : LOCK_TO;
  localparam int CNT_W = $clog2(MAXC + 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;

  assign idle    = (state == ST_IDLE);
  assign ld_div  = (state == ST_WR_DIV);
  assign ld_cfg  = (state == ST_WR_CFG);
  assign ld_frac = (state == ST_WR_FRAC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      bypass      <= 1'b1;
      pll_rst     <= 1'b0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state       <= ST_ENTER;
          bypass      <= 1'b1;
          timeout_err <= 1'b0;
          cnt         <= '0;
        end
        ST_ENTER:   state <= ST_WR_DIV;
        ST_WR_DIV:  state <= ST_WR_CFG;
        ST_WR_CFG:  state <= ST_WR_FRAC;
        ST_WR_FRAC: begin
          state <= ST_RST;
          cnt   <= '0;
        end
        ST_RST: begin
          if (cnt == CNT_W'(RST_CYC)) begin
            pll_rst <= 1'b0;
            cnt     <= '0;
            state   <= ST_SETTLE;
          end else begin
            pll_rst <= 1'b1;
            cnt     <= cnt + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (cnt == CNT_W'(SETTLE_CYC - 1)) begin
            cnt   <= '0;
            state <= ST_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (lock_s) begin
            bypass <= 1'b0;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end else if (cnt == CNT_W'(LOCK_TO - 1)) begin
            timeout_err <= 1'b1;
            state       <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_retune_pkg::*;
#(
  parameter int              FB_W      = 8,
  parameter int              CFG_W     = 10,
  parameter logic [FB_W-1:0] DEF_FBDIV = 8'h20,
  parameter logic [2:0]      DEF_SRC   = 3'b000,
  parameter logic [CFG_W-1:0] DEF_CFG  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              ld_div,
  input  logic              ld_cfg,
  input  logic              ld_frac,
  input  logic [FB_W-1:0]   in_fbdiv,
  input  logic [FRAC_W-1:0] in_frac,
  input  logic              in_frac_en,
  input  logic              in_half,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [CFG_W-1:0]  in_cfg,
  output logic [FB_W-1:0]   o_fbdiv,
  output logic              o_half,
  output logic [SRC_W-1:0]  o_src,
  output logic [CFG_W-1:0]  o_cfg,
  output logic [WORD_W-1:0] o_word
);
  logic [FB_W-1:0]   h_fbdiv;
  logic [FRAC_W-1:0] h_frac;
  logic              h_frac_en;
  logic              h_half;
  logic [SRC_W-1:0]  h_src;
  logic [CFG_W-1:0]  h_cfg;

  // request fields held for the whole sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_fbdiv <= DEF_FBDIV; h_frac <= '0; h_frac_en <= 1'b0;
      h_half  <= 1'b0;      h_src  <= DEF_SRC; h_cfg <= DEF_CFG;
    end else if (capture) begin
      h_fbdiv <= in_fbdiv; h_frac <= in_frac; h_frac_en <= in_frac_en;
      h_half  <= in_half;  h_src  <= in_src;  h_cfg     <= in_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_fbdiv <= DEF_FBDIV;
      o_half  <= 1'b0;
      o_src   <= DEF_SRC;
      o_cfg   <= DEF_CFG;
      o_word  <= '0;
    end else begin
      if (ld_div) begin
        o_fbdiv <= h_fbdiv;
        o_half  <= h_half;
        o_src   <= h_src;
      end
      if (ld_cfg)  o_cfg  <= h_cfg;
      if (ld_frac) o_word <= pack_frac(h_frac_en, h_frac);
    end
  end
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
  import pll_retune_pkg::*;
#(
  parameter int               FB_W       = 8,
  parameter int               CFG_W      = 10,
  parameter int               RST_CYC    = 4,
  parameter int               SETTLE_CYC = 3,
  parameter int               LOCK_TO    = 64,
  parameter int               SYNC_STG   = 2,
  parameter logic [FB_W-1:0]  DEF_FBDIV  = 8'h20,
  parameter logic [2:0]       DEF_SRC    = 3'b000,
  parameter logic [CFG_W-1:0] DEF_CFG    = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [FB_W-1:0]  req_fbdiv,
  input  logic [15:0]      req_frac,
  input  logic             req_frac_en,
  input  logic             req_half,
  input  logic [2:0]       req_src,
  input  logic [CFG_W-1:0] req_loopcfg,
  input  logic             pll_lock,
  output logic             pll_bypass,
  output logic             pll_reset,
  output logic [FB_W-1:0]  pll_fbdiv,
  output logic             pll_half,
  output logic [2:0]       pll_src,
  output logic [CFG_W-1:0] pll_loopcfg,
  output logic [31:0]      pll_fracword,
  output logic             busy,
  output logic             done,
  output logic             timeout_err
);
  logic lock_s, idle, start, ld_div, ld_cfg, ld_frac;

  assign req_ready = idle;
  assign busy      = ~idle;
  assign start     = req_valid & idle;

  pll_lock_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pll_lock), .q(lock_s)
  );

  pll_seq_ctrl #(.RST_CYC(RST_CYC), .SETTLE_CYC(SETTLE_CYC), .LOCK_TO(LOCK_TO)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .lock_s(lock_s), .idle(idle),
    .ld_div(ld_div), .ld_cfg(ld_cfg), .ld_frac(ld_frac), .bypass(pll_bypass),
    .pll_rst(pll_reset), .done(done), .timeout_err(timeout_err)
  );

  pll_cfg_regs #(.FB_W(FB_W), .CFG_W(CFG_W), .DEF_FBDIV(DEF_FBDIV), .DEF_SRC(DEF_SRC),
                 .DEF_CFG(DEF_CFG)) u_regs (
    .clk(clk), .rst_n(rst_n), .capture(start), .ld_div(ld_div), .ld_cfg(ld_cfg),
    .ld_frac(ld_frac), .in_fbdiv(req_fbdiv), .in_frac(req_frac), .in_frac_en(req_frac_en),
    .in_half(req_half), .in_src(req_src), .in_cfg(req_loopcfg), .o_fbdiv(pll_fbdiv),
    .o_half(pll_half), .o_src(pll_src), .o_cfg(pll_loopcfg), .o_word(pll_fracword)
  );
endmodule

// File: rtl/pll_retune_seq_chk.sv
module pll_retune_seq_chk #(
  parameter int FB_W    = 8,
  parameter int CFG_W   = 10,
  parameter int RST_CYC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             pll_lock,
  input logic             pll_bypass,
  input logic             pll_reset,
  input logic [FB_W-1:0]  pll_fbdiv,
  input logic             pll_half,
  input logic [2:0]       pll_src,
  input logic [CFG_W-1:0] pll_loopcfg,
  input logic [31:0]      pll_fracword,
  input logic             done,
  input logic             timeout_err
);
  // R6: minimum pulse width parameter
  initial p_min_width_param_r6: assert (RST_CYC >= 4) else $error("RST_CYC below 4");

  p_reset_under_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pll_reset |-> pll_bypass);
  p_bypass_falls_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_bypass) |-> done);
  p_fields_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pll_reset |-> ($stable(pll_fbdiv) && $stable(pll_half) && $stable(pll_src)
                   && $stable(pll_loopcfg) && $stable(pll_fracword)));
  p_reset_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_reset) |-> ($past(pll_reset, 1) && $past(pll_reset, 2)
                          && $past(pll_reset, 3) && $past(pll_reset, 4)));
  p_done_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(pll_bypass));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_lock_seen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_bypass) |-> $past(pll_lock, 3));
  p_timeout_keeps_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> pll_bypass);
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && $past(req_ready)) |-> ($stable(pll_fbdiv) && $stable(pll_src)
                                         && $stable(pll_loopcfg) && $stable(pll_fracword)));
endmodule

bind pll_retune_seq pll_retune_seq_chk #(.FB_W(FB_W), .CFG_W(CFG_W), .RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .pll_lock(pll_lock),
  .pll_bypass(pll_bypass), .pll_reset(pll_reset), .pll_fbdiv(pll_fbdiv), .pll_half(pll_half),
  .pll_src(pll_src), .pll_loopcfg(pll_loopcfg), .pll_fracword(pll_fracword), .done(done),
  .timeout_err(timeout_err)
);

// File: tb/pll_retune_seq_tb_top.sv
module pll_retune_seq_tb_top;
  localparam int FB_W = 8, CFG_W = 10, RST_CYC = 4, SETTLE_CYC = 3, LOCK_TO = 64;
  localparam int LOCK_DLY = 10;
  localparam int LAT_OK = 6 + RST_CYC + SETTLE_CYC;
  localparam int LAT_TO = 5 + RST_CYC + SETTLE_CYC + LOCK_TO;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_frac_en = 0, req_half = 0, pll_lock = 0;
  logic [FB_W-1:0] req_fbdiv = '0;
  logic [15:0] req_frac = '0;
  logic [2:0] req_src = '0;
  logic [CFG_W-1:0] req_loopcfg = '0;
  logic req_ready, pll_bypass, pll_reset, pll_half, busy, done, timeout_err;
  logic [FB_W-1:0] pll_fbdiv;
  logic [2:0] pll_src;
  logic [CFG_W-1:0] pll_loopcfg;
  logic [31:0] pll_fracword;

  always #4 clk = ~clk;

  pll_retune_seq #(.FB_W(FB_W), .CFG_W(CFG_W), .RST_CYC(RST_CYC), .SETTLE_CYC(SETTLE_CYC),
                   .LOCK_TO(LOCK_TO)) dut_i (.*);

  typedef struct {
    logic [FB_W-1:0] fbdiv; logic half; logic [2:0] src;
    logic [CFG_W-1:0] cfg; logic [31:0] word; bit to; int lat;
  } exp_t;
  exp_t exp_q[$];

  int total = 0, bad = 0;
  int lock_mode = 0;  // 0 normal, 1 never, 2 stuck high
  int lcnt = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, expv);
    end
  endtask

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // PLL lock model
  always @(posedge clk) begin
    if (lock_mode == 2) pll_lock <= 1'b1;
    else if (pll_reset || lock_mode == 1) begin pll_lock <= 1'b0; lcnt <= 0; end
    else if (lcnt < LOCK_DLY) lcnt <= lcnt + 1;
    else pll_lock <= 1'b1;
  end

  // driver: push expected result, then present the request until taken
  task automatic send(input logic [FB_W-1:0] fb, input logic [15:0] fr, input logic en,
                      input logic hf, input logic [2:0] sr, input logic [CFG_W-1:0] cf,
                      input bit to, input int lat);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    e.fbdiv = fb; e.half = hf; e.src = sr; e.cfg = cf;
    e.word = {en, 15'b0, fr}; e.to = to; e.lat = lat;
    exp_q.push_back(e);
    req_fbdiv = fb; req_frac = fr; req_frac_en = en; req_half = hf;
    req_src = sr; req_loopcfg = cf; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  // monitor / scoreboard
  logic p_rst = 0, p_busy = 0, p_done = 0;
  int rst_w = 0, busy_w = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_w++;
      if (pll_reset) rst_w++;
      if (pll_reset && !p_rst) begin
        chk(pll_bypass == 1, "R4 bypass at reset rise", pll_bypass, 1);
        if (exp_q.size() > 0) begin
          chk(pll_fbdiv == exp_q[0].fbdiv, "R5 fbdiv at reset", pll_fbdiv, exp_q[0].fbdiv);
          chk(pll_half == exp_q[0].half, "R5 half at reset", pll_half, exp_q[0].half);
          chk(pll_src == exp_q[0].src, "R5 src at reset", pll_src, exp_q[0].src);
          chk(pll_loopcfg == exp_q[0].cfg, "R5 loopcfg at reset", pll_loopcfg, exp_q[0].cfg);
          chk(pll_fracword == exp_q[0].word, "R5 fracword at reset", pll_fracword, exp_q[0].word);
        end
      end
      if (!pll_reset && p_rst) begin
        chk(rst_w == RST_CYC, "R6 reset width", rst_w, RST_CYC);
        rst_w = 0;
      end
      if (done && p_done) chk(0, "R7 done longer than one cycle", 2, 1);
      if (p_busy && !busy) begin
        if (exp_q.size() == 0) chk(0, "R3 unexpected sequence end", 1, 0);
        else begin
          if (exp_q[0].to) begin
            chk(!done, "R8 no done on timeout", done, 0);
            chk(timeout_err, "R8 timeout flag", timeout_err, 1);
            chk(pll_bypass, "R8 bypass kept", pll_bypass, 1);
          end else begin
            chk(done, "R7 done at end", done, 1);
            chk(!pll_bypass, "R7 bypass released", pll_bypass, 0);
          end
          if (exp_q[0].lat != 0)
            chk(busy_w == exp_q[0].lat, exp_q[0].to ? "R8 busy length" : "R10 busy length",
                busy_w, exp_q[0].lat);
          void'(exp_q.pop_front());
        end
        busy_w = 0;
      end
      p_rst = pll_reset; p_busy = busy; p_done = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(pll_bypass == 1, "R1 bypass", pll_bypass, 1);
    chk(pll_reset == 0, "R1 reset", pll_reset, 0);
    chk(pll_fbdiv == 8'h20, "R1 fbdiv default", pll_fbdiv, 8'h20);
    chk(pll_fracword == 0, "R1 fracword", pll_fracword, 0);
    chk(req_ready && !busy, "R1 ready/busy", {req_ready, busy}, 2'b10);
    chk(!done && !timeout_err, "R1 done/timeout", {done, timeout_err}, 0);

    // normal retune to video source, x80.75 with divide-by-2
    lock_mode = 0;
    send(8'h50, 16'hC000, 1, 1, 3'b100, 10'h15A, 0, 0);
    chk(!req_ready && busy, "R2 busy after accept", {req_ready, busy}, 2'b01);
    wait_idle();
    chk(pll_fracword == 32'h8000C000, "R5 packed word", pll_fracword, 32'h8000C000);
    chk(pll_fbdiv == 8'h50, "R5 divider", pll_fbdiv, 8'h50);
    chk(req_ready, "R2 ready after done", req_ready, 1);

    // lock already high: reset and settle still run in full
    lock_mode = 2;
    send(8'h20, 16'h0000, 0, 0, 3'b000, 10'h000, 0, LAT_OK);
    wait_idle();
    chk(pll_fracword == 0, "R5 enable clear", pll_fracword, 0);

    // no lock: timeout
    lock_mode = 1;
    send(8'h2A, 16'h1234, 1, 0, 3'b010, 10'h3FF, 1, LAT_TO);
    wait_idle();
    repeat (20) @(negedge clk);
    chk(timeout_err, "R8 sticky flag", timeout_err, 1);
    chk(pll_bypass, "R8 bypass after idle", pll_bypass, 1);
    chk(pll_fbdiv == 8'h2A, "R9 divider held", pll_fbdiv, 8'h2A);
    chk(pll_fracword == 32'h80001234, "R9 word held", pll_fracword, 32'h80001234);

    // next request clears the flag
    lock_mode = 0;
    send(8'h33, 16'h8000, 1, 1, 3'b001, 10'h001, 0, 0);
    chk(!timeout_err, "R8 cleared by accept", timeout_err, 0);
    wait_idle();

    // request while busy must be ignored
    send(8'h44, 16'h4000, 1, 0, 3'b011, 10'h0AA, 0, 0);
    repeat (3) @(negedge clk);
    chk(!req_ready, "R2 not ready while busy", req_ready, 0);
    req_fbdiv = 8'hEE; req_frac = 16'hFFFF; req_src = 3'b111; req_loopcfg = 10'h2AA;
    req_valid = 1;
    repeat (3) @(negedge clk);
    req_valid = 0;
    wait_idle();
    chk(pll_fbdiv == 8'h44, "R3 divider untouched", pll_fbdiv, 8'h44);
    chk(pll_src == 3'b011, "R3 source untouched", pll_src, 3'b011);
    repeat (30) @(negedge clk);
    chk(!busy, "R3 no second sequence", busy, 0);
    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    finish_up();
  end
endmodule